// File: doc/BRIEF.md
# Write-Only Two-Wire Tuner Synthesizer Configuration Receiver

This block is a receive-only target on a two-wire serial bus (I2C write transfers only). It loads the setting registers of a tuner PLL synthesizer: a 15-bit loop divide ratio, a 7-bit control word and four band-switch enables. Both bus lines are oversampled by the system clock. They pass through a synchronizer and a glitch filter, and then START, STOP and clock-edge events are detected on them.

Each transfer opens with an address byte. The two bits before the write flag must equal a 2-bit code that is already decoded from a strap pin. Two or four data bytes follow, taken as pairs. The top bit of the first byte of a pair selects its role. A 0 makes the pair a divider pair: its high seven bits come first, then its low eight bits. A 1 makes the pair a control/band pair: the control byte comes first, then the band byte. The divider ratio is committed as a whole once its second byte is complete. The control and band bytes each take effect as soon as they arrive. The outputs are plain level registers that feed the synthesizer, so no stream handshake appears at this boundary.

Top module: `synth_cfg_rx`

## Requirements
- R1: After reset the registers hold these values: div_word=0, band_en=0, cp_hi=1, test_mode=3'b010 (pump high-impedance), ref_sel=2'b01 (1/1024), tune_off=1. sda_pull is 0.
- R2: An address byte is accepted only when it equals {5'b11000, addr_sel, 1'b0}, sent MSB first. The receiver then pulls SDA low for the acknowledge clock. Any other address gets no acknowledge, and the rest of the transfer up to the next START has no effect.
- R3: Bit 7 of data bytes 1 and 3 is a function bit. A 0 marks that byte and the byte after it as a divider pair. A 1 marks them as a control/band pair.
- R4: div_word = {D1[6:0], D2[7:0]}. It changes only when the eighth bit of D2 is clocked in. A D1 that is followed by STOP or by an acknowledge alone leaves div_word unchanged.
- R5: The control byte updates {cp_hi, test_mode[2:0], ref_sel[1:0], tune_off} from its bits 6..0 at its own eighth bit. The band outputs stay untouched until the band byte arrives.
- R6: The band byte sets band_en from its bits 3..0 at its own eighth bit. Bits 7..4 are ignored.
- R7: Each of data bytes 1 to 4 of an accepted transfer is acknowledged. A fifth data byte gets no acknowledge and changes nothing.
- R8: A START or STOP inside a byte drops the bits already received. Registers that were committed earlier keep their values, and a new transfer after a repeated START works normally.
- R9: A pulse on SCL or SDA that is shorter than FILT_LEN system clocks is ignored.
- R10: sda_pull is only asserted and released while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on state) |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| addr_sel | input | 2 | Decoded strap code that the address bits must match |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| div_word | output | 15 | Loop divide ratio |
| cp_hi | output | 1 | Charge pump high-current select |
| test_mode | output | 3 | Pump/test mode field |
| ref_sel | output | 2 | Reference divide select |
| tune_off | output | 1 | Tuning amplifier disable |
| band_en | output | 4 | Band switch enables |

## Verification
A table drives the four legal byte orders (control then band, divider alone, control/band followed by divider, divider followed by control/band). It also drives a wrong strap address and a read flag. Register results after each transfer show whether the function bit steered each pair to the right target. The acknowledge bit of every byte shows whether the address decode is right. Directed cases check the registers between bytes to pin down when commits happen. They also send a fifth data byte, a D1 that is never completed, STOP and repeated START inside a byte, a second strap code, and one-clock glitches on both lines.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;
  localparam int DIV_W      = 15;
  localparam int CTRL_W     = 7;
  localparam int BAND_W     = 4;
  localparam int BYTE_BITS  = 8;
  localparam int MAX_DATA   = 4;
  localparam logic [4:0]        ADDR_PREFIX  = 5'b11000;
  // {cp_hi, test_mode, ref_sel, tune_off}
  localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 7'b1_010_01_1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/cfg_line_filter.sv
`timescale 1ns/1ps
module cfg_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   samp;

  assign samp = sync_q[SYNC_STAGES-1];

  // Output follows the synchronized line only after FILT_LEN equal samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (samp == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= samp;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_bus_fsm.sv
`timescale 1ns/1ps
module cfg_bus_fsm
  import synth_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [1:0] addr_sel,
  output logic       sda_pull,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic [2:0] byte_idx
);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_BITS - 1);

  rx_state_t  state;
  logic       scl_q, sda_q;
  logic       got8, take;
  logic [2:0] bit_cnt;
  logic [2:0] idx;
  logic [6:0] sh;
  logic [7:0] full;
  logic       start_ev, stop_ev, scl_rise, scl_fall;
  logic       addr_hit, data_slot;

  assign full      = {sh, sda_f};
  assign start_ev  = scl_q & scl_f & sda_q & ~sda_f;
  assign stop_ev   = scl_q & scl_f & ~sda_q & sda_f;
  assign scl_rise  = ~scl_q & scl_f;
  assign scl_fall  = scl_q & ~scl_f;
  assign addr_hit  = (full[7:3] == ADDR_PREFIX) && (full[2:1] == addr_sel) && !full[0];
  assign data_slot = (idx != 3'd0) && (idx <= 3'(MAX_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      got8      <= 1'b0;
      take      <= 1'b0;
      bit_cnt   <= '0;
      idx       <= '0;
      sh        <= '0;
      sda_pull  <= 1'b0;
      byte_stb  <= 1'b0;
      byte_data <= '0;
      byte_idx  <= '0;
    end else begin
      scl_q    <= scl_f;
      sda_q    <= sda_f;
      byte_stb <= 1'b0;
      if (start_ev) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        idx      <= '0;
        got8     <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        got8     <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && !got8) begin
              sh <= full[6:0];
              if (bit_cnt == LAST_BIT) begin
                got8 <= 1'b1;
                take <= (idx == 3'd0) ? addr_hit : data_slot;
                if (data_slot) begin
                  byte_stb  <= 1'b1;
                  byte_data <= full;
                  byte_idx  <= idx;
                end
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end else if (scl_fall && got8) begin
              got8 <= 1'b0;
              if (take) begin
                state    <= ST_ACK;
                sda_pull <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_RX;
              bit_cnt  <= '0;
              if (idx != 3'd7) idx <= idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic [2:0]        byte_idx,
  output logic [DIV_W-1:0]  div_word,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [BAND_W-1:0] band_en,
  output logic              wr_div,
  output logic              wr_cb,
  output logic              wr_bb
);
  localparam int HI_W = DIV_W - BYTE_BITS;

  logic            pair_ctl;
  logic [HI_W-1:0] d1_hold;
  logic            first;

  // Odd data slots open a pair; their top bit names the pair's role.
  assign first  = byte_idx[0];
  assign wr_cb  = byte_stb & first & byte_data[7];
  assign wr_div = byte_stb & ~first & ~pair_ctl;
  assign wr_bb  = byte_stb & ~first & pair_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_ctl  <= 1'b0;
      d1_hold   <= '0;
      div_word  <= '0;
      ctrl_word <= CTRL_DEFAULT;
      band_en   <= '0;
    end else begin
      if (byte_stb && first) begin
        pair_ctl <= byte_data[7];
        if (!byte_data[7]) d1_hold <= byte_data[HI_W-1:0];
      end
      if (wr_cb)  ctrl_word <= byte_data[CTRL_W-1:0];
      if (wr_div) div_word  <= {d1_hold, byte_data};
      if (wr_bb)  band_en   <= byte_data[BAND_W-1:0];
    end
  end
endmodule

// File: rtl/synth_cfg_rx.sv
`timescale 1ns/1ps
module synth_cfg_rx
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [1:0]  addr_sel,
  output logic        sda_pull,
  output logic [14:0] div_word,
  output logic        cp_hi,
  output logic [2:0]  test_mode,
  output logic [1:0]  ref_sel,
  output logic        tune_off,
  output logic [3:0]  band_en
);
  localparam int LINES = 2;

  logic [LINES-1:0]  line_raw, line_filt;
  logic              scl_filt, sda_filt;
  logic              byte_stb;
  logic [7:0]        byte_data;
  logic [2:0]        byte_idx;
  logic [CTRL_W-1:0] ctrl_word;
  logic              wr_div, wr_cb, wr_bb;

  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    cfg_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw[g]),
      .dout (line_filt[g])
    );
  end

  assign scl_filt = line_filt[0];
  assign sda_filt = line_filt[1];

  cfg_bus_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_filt),
    .sda_f    (sda_filt),
    .addr_sel (addr_sel),
    .sda_pull (sda_pull),
    .byte_stb (byte_stb),
    .byte_data(byte_data),
    .byte_idx (byte_idx)
  );

  cfg_reg_bank u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_stb (byte_stb),
    .byte_data(byte_data),
    .byte_idx (byte_idx),
    .div_word (div_word),
    .ctrl_word(ctrl_word),
    .band_en  (band_en),
    .wr_div   (wr_div),
    .wr_cb    (wr_cb),
    .wr_bb    (wr_bb)
  );

  assign cp_hi     = ctrl_word[6];
  assign test_mode = ctrl_word[5:3];
  assign ref_sel   = ctrl_word[2:1];
  assign tune_off  = ctrl_word[0];
endmodule

// File: rtl/synth_cfg_rx_chk.sv
`timescale 1ns/1ps
module synth_cfg_rx_chk
  import synth_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_filt,
  input logic              sda_pull,
  input logic [DIV_W-1:0]  div_word,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [BAND_W-1:0] band_en,
  input logic              wr_div,
  input logic              wr_cb,
  input logic              wr_bb
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (div_word == '0 && band_en == '0 && ctrl_word == CTRL_DEFAULT && !sda_pull));

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_div, wr_cb, wr_bb}));

  // R4
  div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_word) |-> !sda_pull);

  // R6
  band_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_en) |-> !sda_pull);

  // R10
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_filt);

  // R10
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_filt);
endmodule

bind synth_cfg_rx synth_cfg_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_filt (scl_filt),
  .sda_pull (sda_pull),
  .div_word (div_word),
  .ctrl_word(ctrl_word),
  .band_en  (band_en),
  .wr_div   (wr_div),
  .wr_cb    (wr_cb),
  .wr_bb    (wr_bb)
);

// File: tb/synth_cfg_rx_tb.sv
`timescale 1ns/1ps
module synth_cfg_rx_tb;
  localparam int Q = 200;

  typedef struct packed {
    logic [2:0]  n;
    logic [39:0] bytes;
    logic [4:0]  ackm;
    logic [14:0] div;
    logic [6:0]  cb;
    logic [3:0]  bb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 40'hC0_8E_05_00_00, 5'b00111, 15'h0000, 7'h0E, 4'h5},
    '{3'd3, 40'hC0_12_34_00_00, 5'b00111, 15'h1234, 7'h0E, 4'h5},
    '{3'd5, 40'hC0_F3_0A_7F_FF, 5'b11111, 15'h7FFF, 7'h73, 4'hA},
    '{3'd5, 40'hC0_00_01_80_06, 5'b11111, 15'h0001, 7'h00, 4'h6},
    '{3'd3, 40'hC2_55_66_00_00, 5'b00000, 15'h0001, 7'h00, 4'h6},
    '{3'd3, 40'hC1_12_34_00_00, 5'b00000, 15'h0001, 7'h00, 4'h6},
    '{3'd3, 40'hC0_2A_55_00_00, 5'b00111, 15'h2A55, 7'h00, 4'h6},
    '{3'd3, 40'hC0_C9_F3_00_00, 5'b00111, 15'h2A55, 7'h49, 4'h3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_drv = 1'b1;
  logic        sda_drv = 1'b1;
  logic [1:0]  addr_sel = 2'b00;
  logic        sda_pull;
  logic [14:0] div_word;
  logic        cp_hi, tune_off;
  logic [2:0]  test_mode;
  logic [1:0]  ref_sel;
  logic [3:0]  band_en;
  logic        sda_line;
  logic [6:0]  cb_now;
  int          checks = 0;
  int          errors = 0;
  logic        ack;

  assign sda_line = sda_drv & ~sda_pull;
  assign cb_now   = {cp_hi, test_mode, ref_sel, tune_off};

  always #10 clk = ~clk;

  synth_cfg_rx u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_drv),
    .sda_in   (sda_line),
    .addr_sel (addr_sel),
    .sda_pull (sda_pull),
    .div_word (div_word),
    .cp_hi    (cp_hi),
    .test_mode(test_mode),
    .ref_sel  (ref_sel),
    .tune_off (tune_off),
    .band_en  (band_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b1; #Q;
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b1; #Q;
    sda_drv = 1'b1; #(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 0; i < nb; i++) begin
      sda_drv = b[7-i]; #Q;
      scl_drv = 1'b1;   #(2*Q);
      scl_drv = 1'b0;   #Q;
    end
  endtask

  // glitch != 0 adds a 20 ns SCL pulse in a low phase and a 20 ns SDA flip in a high phase
  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i];
      if (glitch && i == 4) begin
        #(Q/2); scl_drv = 1'b1; #20; scl_drv = 1'b0; #(Q/2 - 20);
        scl_drv = 1'b1; #Q; sda_drv = ~b[i]; #20; sda_drv = b[i]; #(Q - 20);
      end else begin
        #Q; scl_drv = 1'b1; #(2*Q);
      end
      scl_drv = 1'b0; #Q;
    end
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b1; #Q;
    acked = ~sda_line;
    #Q;
    scl_drv = 1'b0; #Q;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #105;
    rst_n = 1'b1;
    #200;
    // R1 power-on state
    check("R1 div_word", 32'(div_word), 32'h0);
    check("R1 ctrl", 32'(cb_now), 32'h53);
    check("R1 band_en", 32'(band_en), 32'h0);
    check("R1 sda_pull", 32'(sda_pull), 32'h0);

    // R2 R3 R4 R5 R6: table of transfers
    for (int v = 0; v < NV; v++) begin
      bus_start();
      for (int k = 0; k < int'(VEC[v].n); k++) begin
        send_byte(VEC[v].bytes[39-8*k -: 8], 1'b0, ack);
        check($sformatf("R2 ack vec%0d byte%0d", v, k), 32'(ack), 32'(VEC[v].ackm[k]));
      end
      bus_stop();
      check($sformatf("R4 div vec%0d", v), 32'(div_word), 32'(VEC[v].div));
      check($sformatf("R5 ctrl vec%0d", v), 32'(cb_now), 32'(VEC[v].cb));
      check($sformatf("R6 band vec%0d", v), 32'(band_en), 32'(VEC[v].bb));
    end

    // R4 R5 R6 R7 commit points inside one transfer
    bus_start();
    send_byte(8'hC0, 1'b0, ack);
    send_byte(8'h15, 1'b0, ack);
    check("R4 div held after D1", 32'(div_word), 32'h2A55);
    send_byte(8'h66, 1'b0, ack);
    check("R4 div after D2", 32'(div_word), 32'h1566);
    send_byte(8'hFF, 1'b0, ack);
    check("R5 ctrl after CB", 32'(cb_now), 32'h7F);
    check("R5 band held after CB", 32'(band_en), 32'h3);
    send_byte(8'hF0, 1'b0, ack);
    check("R6 band upper bits ignored", 32'(band_en), 32'h0);
    send_byte(8'h12, 1'b0, ack);
    check("R7 fifth byte nack", 32'(ack), 32'h0);
    bus_stop();
    check("R7 no effect div", 32'(div_word), 32'h1566);
    check("R7 no effect ctrl", 32'(cb_now), 32'h7F);
    check("R7 no effect band", 32'(band_en), 32'h0);

    // R4 lone D1
    bus_start();
    send_byte(8'hC0, 1'b0, ack);
    send_byte(8'h3F, 1'b0, ack);
    bus_stop();
    check("R4 lone D1", 32'(div_word), 32'h1566);

    // R8 STOP mid-byte
    bus_start();
    send_byte(8'hC0, 1'b0, ack);
    send_bits(8'h85, 4);
    bus_stop();
    check("R8 stop mid-byte ctrl", 32'(cb_now), 32'h7F);
    check("R8 stop mid-byte pull", 32'(sda_pull), 32'h0);

    // R8 repeated START mid-byte
    bus_start();
    send_byte(8'hC0, 1'b0, ack);
    send_bits(8'hA0, 3);
    bus_start();
    send_byte(8'hC0, 1'b0, ack);
    check("R8 restart address ack", 32'(ack), 32'h1);
    send_byte(8'h9C, 1'b0, ack);
    send_byte(8'h01, 1'b0, ack);
    bus_stop();
    check("R8 restart ctrl", 32'(cb_now), 32'h1C);
    check("R8 restart band", 32'(band_en), 32'h1);

    // R2 other strap code
    addr_sel = 2'b10;
    bus_start();
    send_byte(8'hC4, 1'b0, ack);
    check("R2 strap 10 ack", 32'(ack), 32'h1);
    send_byte(8'h8C, 1'b0, ack);
    send_byte(8'h07, 1'b0, ack);
    bus_stop();
    check("R2 strap 10 ctrl", 32'(cb_now), 32'h0C);
    bus_start();
    send_byte(8'hC0, 1'b0, ack);
    check("R2 old address nack", 32'(ack), 32'h0);
    send_byte(8'h88, 1'b0, ack);
    send_byte(8'h01, 1'b0, ack);
    bus_stop();
    check("R2 ignored ctrl", 32'(cb_now), 32'h0C);
    check("R2 ignored band", 32'(band_en), 32'h7);
    addr_sel = 2'b00;

    // R9 glitches on both lines
    bus_start();
    send_byte(8'hC0, 1'b0, ack);
    send_byte(8'h8A, 1'b1, ack);
    check("R9 glitched byte ack", 32'(ack), 32'h1);
    send_byte(8'h0C, 1'b0, ack);
    bus_stop();
    check("R9 glitched ctrl", 32'(cb_now), 32'h0A);
    check("R9 band", 32'(band_en), 32'hC);
    check("R10 pull idle", 32'(sda_pull), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule